// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block models a single-port synchronous SRAM whose 32-bit word is divided into four byte lanes, with a pipelined read path. Every control and data input is sampled on the rising clock edge. An access begins when either of two address strobes is asserted. One strobe is meant for a processor and the other for a memory controller. Once an access has begun, a two-bit burst counter steps through the four words of an aligned group. It can use a linear (wrapping increment) order or an interleaved (XOR) order, chosen by an input.

A read returns its word through an array read register, and an output-enable input gates the bus drive without waiting for a clock. The bus is modelled as a data output together with a drive flag. A low drive flag stands for high impedance, and the data output is then all zeros.

A write can cover any subset of the four byte lanes, or all of them through a global write input. Three chip-select inputs take part in depth expansion. They are sampled only when a strobe starts an access.

Top module: `psram_pipe_burst`

## Requirements
- R1: While reset is high, and after its release until the first read completes, `rdata_drv` is 0 and `rdata` is 0.
- R2: A strobe selects the chip only when `sel_n`=0, `sel_hi`=1 and `sel_lo_n`=0. Otherwise the block stays deselected until the next strobe. While it is deselected, write controls change no stored word and nothing is driven.
- R3: `strb_ctl_n`=0 always starts an access. `strb_cpu_n`=0 starts one only while `sel_n`=0, and otherwise the ongoing access continues unchanged. A controller strobe with `sel_n`=1 deselects the chip.
- R4: A read whose address is sampled at rising edge k drives its word on `rdata` from just after edge k+1 until edge k+2. With the strobe cycle counted as the first clock, the word is therefore available at the third clock.
- R5: With the chip selected and `adv_n`=0 on a cycle without a strobe, address bits 1:0 step once. When `linear_burst`=1 they take the values (start+n) mod 4. When `linear_burst`=0 they take start XOR n. Bits above 1 stay fixed. With `adv_n`=1 the same address is read again each cycle.
- R6: `lane_wr_n[i]`=0 writes `wdata[8i+7:8i]` into the same bits of the word, but only while `lanes_arm_n`=0. When `lanes_arm_n`=1 and `wr_all_n`=1, the cycle is a read and nothing is written.
- R7: `wr_all_n`=0 writes all four lanes, whatever `lane_wr_n` and `lanes_arm_n` hold.
- R8: The bus is not driven in the cycle after a write's pipeline stage, that is, just after edge k+1 for a write sampled at edge k.
- R9: `drive_en_n` acts without a clock. When it is 1, `rdata_drv` is 0 and `rdata` is 0 at once. When it returns to 0, the pending read word reappears in the same cycle.
- R10: When a strobe deselects the chip at edge k+1, just after a read sampled at edge k, that read's word is still driven after edge k+1. The bus is released after edge k+2.
- R11: A read issued in the cycle right after a write to the same address returns the newly written bytes merged with the bytes that were not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW (6) | Word address, loaded by a strobe |
| wdata | input | 32 | Write data, four byte lanes |
| sel_n | input | 1 | Primary chip select, active low, also qualifies the processor strobe |
| sel_hi | input | 1 | Expansion select, active high |
| sel_lo_n | input | 1 | Expansion select, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| lanes_arm_n | input | 1 | Master enable for per-lane writes, active low |
| lane_wr_n | input | 4 | Per-lane write enables, active low, bit i is byte i |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| linear_burst | input | 1 | 1 selects linear order, 0 selects interleaved order |
| drive_en_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 32 | Read data, zero when not driven |
| rdata_drv | output | 1 | 1 when the bus is driven, 0 for high impedance |

## Verification
The array is first filled with a distinct word per address, so that any wrong address or wrong lane shows up as a wrong value. Bursts run from a start address whose low bits are 01 in both orders, because that start gives a different sequence in each order, while some other starts give the same one. Lane writes use sparse masks with the master enable on and off, and also with the global write overriding a mask, so that a lane mapping error is told apart from a gating error. Strobe patterns combine both strobes with the primary select high and low. Deselects and output-enable changes are placed directly after reads, so that the two-edge release and the unclocked gating can be seen apart from the read latency.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_t;

    // All three selects must agree for the chip to respond
    function automatic logic chip_selected(logic s_n, logic s_hi, logic s_lo_n);
        return !s_n && s_hi && !s_lo_n;
    endfunction

    // Low address bits for burst step 'step' from start 'base'
    function automatic logic [BURST_W-1:0] burst_offset(logic [BURST_W-1:0] base,
                                                        logic [BURST_W-1:0] step,
                                                        logic linear);
        return linear ? (base + step) : (base ^ step);
    endfunction

endpackage

// File: rtl/psram_burst_ctr.sv
module psram_burst_ctr
    import psram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          advance,
    input  logic          linear,
    output logic [AW-1:0] addr_now
);

    logic [AW-1:0]      base_q;
    logic [BURST_W-1:0] step_q;
    logic [BURST_W-1:0] step_use;

    assign step_use = advance ? step_q + 1'b1 : step_q;

    always_comb begin
        if (load)
            addr_now = load_addr;
        else
            addr_now = {base_q[AW-1:BURST_W],
                        burst_offset(base_q[BURST_W-1:0], step_use, linear)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            step_q <= '0;
        end else if (load) begin
            base_q <= load_addr;
            step_q <= '0;
        end else if (advance) begin
            step_q <= step_q + 1'b1;
        end
    end

    // R5: without load or advance for two cycles the address holds
    assert_burst_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) ##1 (!load && !advance && $stable(linear)) |-> $stable(addr_now));

    // R5: upper address bits never move during a burst step
    assert_burst_upper_R5: assert property (@(posedge clk) disable iff (rst)
        (!load && advance) ##1 (!load) |-> (addr_now[AW-1:BURST_W] == $past(addr_now[AW-1:BURST_W])));

endmodule

// File: rtl/psram_array.sv
module psram_array #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic                    re,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        lanes,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rword
);

    localparam int DW    = LANES * LANE_W;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < LANES; i++) begin
                if (lanes[i])
                    mem[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
            end
        end
        if (re)
            rword <= mem[addr];
    end

endmodule

// File: rtl/psram_out_drv.sv
module psram_out_drv #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          read_done,
    input  logic [DW-1:0] word_in,
    input  logic          oe_n,
    output logic [DW-1:0] data_o,
    output logic          drv_o
);

    logic valid_q;

    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= 1'b0;
        else
            valid_q <= read_done;
    end

    assign drv_o  = valid_q && !oe_n;
    assign data_o = drv_o ? word_in : '0;

endmodule

// File: rtl/psram_pipe_burst.sv
module psram_pipe_burst
    import psram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    sel_n,
    input  logic                    sel_hi,
    input  logic                    sel_lo_n,
    input  logic                    strb_cpu_n,
    input  logic                    strb_ctl_n,
    input  logic                    adv_n,
    input  logic                    lanes_arm_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    wr_all_n,
    input  logic                    linear_burst,
    input  logic                    drive_en_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_drv
);

    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        op_t              op;
        logic [AW-1:0]    addr;
        logic [LANES-1:0] lanes;
        logic [DW-1:0]    data;
    } req_t;

    logic             start;
    logic             chip_hit;
    logic             sel_q;
    logic             eff_sel;
    logic             advance;
    logic [AW-1:0]    addr_now;
    logic [LANES-1:0] lane_sel;
    req_t             req_d, st1;
    logic [DW-1:0]    rword;

    // Controller strobe always starts; processor strobe needs primary select
    assign start    = !strb_ctl_n || (!strb_cpu_n && !sel_n);
    assign chip_hit = chip_selected(sel_n, sel_hi, sel_lo_n);
    assign eff_sel  = start ? chip_hit : sel_q;
    assign advance  = !start && sel_q && !adv_n;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_sel[g] = !wr_all_n || (!lanes_arm_n && !lane_wr_n[g]);
    end

    psram_burst_ctr #(.AW(AW)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .load_addr (addr),
        .advance   (advance),
        .linear    (linear_burst),
        .addr_now  (addr_now)
    );

    always_comb begin
        req_d.addr  = addr_now;
        req_d.lanes = lane_sel;
        req_d.data  = wdata;
        if (!eff_sel)
            req_d.op = OP_IDLE;
        else if (|lane_sel)
            req_d.op = OP_WRITE;
        else
            req_d.op = OP_READ;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
            st1   <= '0;
        end else begin
            if (start)
                sel_q <= chip_hit;
            st1 <= req_d;
        end
    end

    psram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk   (clk),
        .we    (st1.op == OP_WRITE),
        .re    (st1.op == OP_READ),
        .addr  (st1.addr),
        .lanes (st1.lanes),
        .wdata (st1.data),
        .rword (rword)
    );

    psram_out_drv #(.DW(DW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .read_done (st1.op == OP_READ),
        .word_in   (rword),
        .oe_n      (drive_en_n),
        .data_o    (rdata),
        .drv_o     (rdata_drv)
    );

    // R4: a read in the request stage drives the bus one edge later
    assert_read_pipe_R4: assert property (@(posedge clk) disable iff (rst)
        (st1.op == OP_READ) |=> (rdata_drv == !drive_en_n));

    // R8: anything other than a read leaves the bus released next cycle
    assert_write_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (st1.op != OP_READ) |=> !rdata_drv);

    // R10: a deselecting strobe produces an idle request stage
    assert_deselect_R10: assert property (@(posedge clk) disable iff (rst)
        (start && !chip_hit) |=> (st1.op == OP_IDLE));

    // R3: processor strobe with primary select high keeps the chip selected
    assert_cpu_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (strb_ctl_n && !strb_cpu_n && sel_n && sel_q) |=> sel_q);

    // R7: global write produces a full-lane write request
    assert_global_write_R7: assert property (@(posedge clk) disable iff (rst)
        (!wr_all_n && eff_sel) |=> (st1.op == OP_WRITE && st1.lanes == '1));

    // R6: no write request without the lane master enable or global write
    assert_lane_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_all_n && lanes_arm_n) |=> (st1.op != OP_WRITE));

    // R9: an undriven bus carries zeros
    always_comb begin
        assert_float_zero_R9: assert (rdata_drv || rdata == '0);
    end

endmodule

// File: tb/psram_pipe_burst_tb_top.sv
module psram_pipe_burst_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        sel_n = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0;
    logic        strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1;
    logic        lanes_arm_n = 1'b1, wr_all_n = 1'b1;
    logic [3:0]  lane_wr_n = 4'hF;
    logic        linear_burst = 1'b1, drive_en_n = 1'b0;
    logic [31:0] rdata;
    logic        rdata_drv;

    int    checks = 0;
    int    fails  = 0;
    bit    finished = 1'b0;
    string tag = "R1";

    always #4 clk = ~clk;

    psram_pipe_burst dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .sel_n(sel_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
        .lanes_arm_n(lanes_arm_n), .lane_wr_n(lane_wr_n), .wr_all_n(wr_all_n),
        .linear_burst(linear_burst), .drive_en_n(drive_en_n),
        .rdata(rdata), .rdata_drv(rdata_drv)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_mem [64];
    bit          m_sel = 0;
    int          m_base = 0, m_cnt = 0;
    bit          p_v = 0, p_rd = 0;
    int          p_a = 0;
    logic [3:0]  p_l = '0;
    logic [31:0] p_d = '0;
    bit          o_v = 0;
    logic [31:0] o_d = '0;

    function automatic int burst_addr(int base, int cnt, bit lin);
        int lo;
        lo = lin ? ((base + cnt) % 4) : ((base ^ cnt) & 3);
        return (base & ~3) | lo;
    endfunction

    task automatic compare(string t, logic e_drv, logic [31:0] e_dat);
        checks++;
        if (rdata_drv !== e_drv || rdata !== e_dat) begin
            fails++;
            $display("FAIL %s: got drv=%0b data=%h, expected drv=%0b data=%h",
                     t, rdata_drv, rdata, e_drv, e_dat);
        end
    endtask

    always @(posedge clk) begin : model
        bit         st;
        int         a;
        logic [3:0] ln;
        logic       e_drv;
        if (rst) begin
            m_sel = 0; p_v = 0; o_v = 0; m_base = 0; m_cnt = 0;
        end else begin
            if (p_v && p_rd) begin
                o_d = m_mem[p_a];
                o_v = 1;
            end else begin
                o_v = 0;
                if (p_v)
                    for (int i = 0; i < 4; i++)
                        if (p_l[i]) m_mem[p_a][i*8 +: 8] = p_d[i*8 +: 8];
            end
            st = !strb_ctl_n || (!strb_cpu_n && !sel_n);
            if (st) begin
                m_sel  = !sel_n && sel_hi && !sel_lo_n;
                m_base = int'(addr);
                m_cnt  = 0;
            end else if (m_sel && !adv_n) begin
                m_cnt = (m_cnt + 1) % 4;
            end
            a  = burst_addr(m_base, m_cnt, linear_burst);
            ln = !wr_all_n ? 4'hF : (!lanes_arm_n ? ~lane_wr_n : 4'h0);
            p_v  = m_sel;
            p_rd = (ln == 4'h0);
            p_a  = a;
            p_l  = ln;
            p_d  = wdata;
        end
        #3;
        e_drv = o_v && !drive_en_n;
        compare(tag, e_drv, e_drv ? o_d : 32'h0);
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [31:0] fill(int a);
        return 32'h5A00_0000 + a * 32'h0001_0203;
    endfunction

    task automatic idle();
        strb_ctl_n = 1; strb_cpu_n = 1; adv_n = 1;
        lanes_arm_n = 1; wr_all_n = 1; lane_wr_n = 4'hF;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic wr_word(int a, logic [31:0] d);
        strb_ctl_n = 0; addr = 6'(a); wr_all_n = 0; wdata = d;
        tick();
    endtask

    task automatic rd(int a, bit cpu);
        if (cpu) strb_cpu_n = 0; else strb_ctl_n = 0;
        addr = 6'(a);
        tick();
    endtask

    task automatic adv();
        adv_n = 0;
        tick();
    endtask

    task automatic deselect();
        strb_ctl_n = 0; sel_hi = 0;
        tick();
        sel_hi = 1;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        checks++; fails++;
        $display("FAIL watchdog: got no completion, expected end of stimulus");
        report();
    end

    // ---------------- directed scenarios ----------------
    initial begin
        idle();
        repeat (3) @(negedge clk);
        compare("R1", 1'b0, 32'h0);
        rst = 0;
        tick();
        compare("R1", 1'b0, 32'h0);

        // R7: fill every word with global writes
        tag = "R7";
        for (int a = 0; a < 64; a++) wr_word(a, fill(a));

        // R4: first word on the third clock, via processor strobe
        tag = "R4";
        deselect(); tick(); tick();
        rd(5, 1);
        compare("R4", 1'b0, 32'h0);
        tick();
        compare("R4", 1'b1, fill(5));

        // R5: linear burst from low bits 01
        tag = "R5";
        linear_burst = 1;
        rd(9, 0);
        adv(); compare("R5", 1'b1, fill(9));
        adv(); compare("R5", 1'b1, fill(10));
        adv(); compare("R5", 1'b1, fill(11));
        tick(); compare("R5", 1'b1, fill(8));
        tick(); compare("R5", 1'b1, fill(8));
        // R5: interleaved burst from the same start
        linear_burst = 0;
        rd(9, 0);
        adv(); compare("R5", 1'b1, fill(9));
        adv(); compare("R5", 1'b1, fill(8));
        adv(); compare("R5", 1'b1, fill(11));
        tick(); compare("R5", 1'b1, fill(10));
        linear_burst = 1;

        // R6: lanes 0 and 2 written; unarmed enables ignored
        tag = "R6";
        strb_ctl_n = 0; addr = 6'd20; lanes_arm_n = 0; lane_wr_n = 4'b1010;
        wdata = 32'hFFFF_FFFF;
        tick();
        strb_ctl_n = 0; addr = 6'd21; lanes_arm_n = 1; lane_wr_n = 4'b0000;
        wdata = 32'h0;
        tick();
        rd(20, 0); tick();
        compare("R6", 1'b1, (fill(20) & 32'hFF00_FF00) | 32'h00FF_00FF);
        rd(21, 0); tick();
        compare("R6", 1'b1, fill(21));

        // R7: global write overrides a sparse lane mask
        tag = "R7";
        strb_ctl_n = 0; addr = 6'd22; wr_all_n = 0; lanes_arm_n = 0;
        lane_wr_n = 4'b1110; wdata = 32'h1357_9BDF;
        tick();
        rd(22, 0); tick();
        compare("R7", 1'b1, 32'h1357_9BDF);

        // R8 and R11: write then immediate read of the same word
        tag = "R11";
        wr_word(30, 32'hDEAD_BEEF);
        rd(30, 0);
        compare("R8", 1'b0, 32'h0);
        tick();
        compare("R11", 1'b1, 32'hDEAD_BEEF);
        strb_ctl_n = 0; addr = 6'd31; lanes_arm_n = 0; lane_wr_n = 4'b0111;
        wdata = 32'hAB00_0000;
        tick();
        rd(31, 0); tick();
        compare("R11", 1'b1, (fill(31) & 32'h00FF_FFFF) | 32'hAB00_0000);

        // R9: output enable without a clock
        tag = "R9";
        rd(40, 0); tick();
        compare("R9", 1'b1, fill(40));
        drive_en_n = 1; #1;
        compare("R9", 1'b0, 32'h0);
        drive_en_n = 0; #1;
        compare("R9", 1'b1, fill(40));
        tick();

        // R10: deselect right after a read
        tag = "R10";
        rd(41, 0);
        deselect();
        compare("R10", 1'b1, fill(41));
        tick();
        compare("R10", 1'b0, 32'h0);

        // R3: processor strobe ignored with primary select high
        tag = "R3";
        rd(42, 0); tick();
        compare("R3", 1'b1, fill(42));
        strb_cpu_n = 0; sel_n = 1; addr = 6'd43;
        tick();
        sel_n = 0;
        tick();
        compare("R3", 1'b1, fill(42));
        strb_ctl_n = 0; sel_n = 1; addr = 6'd43;
        tick();
        sel_n = 0;
        tick();
        compare("R3", 1'b0, 32'h0);

        // R2: expansion select wrong: no write, no drive
        tag = "R2";
        strb_ctl_n = 0; sel_lo_n = 1; addr = 6'd44; wr_all_n = 0; wdata = 32'h0;
        tick();
        sel_lo_n = 0; wr_all_n = 0; wdata = 32'h0;
        tick();
        tick();
        compare("R2", 1'b0, 32'h0);
        rd(44, 0); tick();
        compare("R2", 1'b1, fill(44));

        tick(); tick();
        report();
    end

endmodule